// File: doc/BRIEF.md
# Multi-Pipe Interrupt Source Aggregator

This block gathers the interrupt requests of a parameterised number of DMA pipes, up to 31, together with four controller-level causes. It presents them to several execution environments. Each pipe request is a level input. The four global causes are event pulses. Each pulse is latched into a sticky status bit, and the status bits are gated by an enable register to form one controller-level interrupt.

Every execution environment sees the same 32-bit source word. The low bits carry one bit per pipe and the top bit carries the controller-level interrupt. Each environment owns an unmask register and a level-high interrupt line. The line is high while any source bit that the environment has unmasked is set.

Software reaches all registers through a simple register port. A write takes effect at the clock edge. A read returns its data one cycle after the request. Status bits are cleared by writing ones to a separate clear register.

Top module: `irq_aggregator`

## Requirements
- R1: After reset the status, enable and all unmask registers hold zero, every irq_o line is low, and every readable register returns zero.
- R2: A pulse on gevt_i[k] sets global status bit k+1. The mapping is: bit 1 bus response error, bit 2 error, bit 3 empty, bit 4 timer. The bit stays set until a write to the clear register (offset 0x028) with a 1 in that bit position. Zeros written there have no effect. The status register is at offset 0x020, and the clear register reads zero.
- R3: When a clear write and a new event hit the same status bit in the same cycle, the bit remains set.
- R4: The global enable register (offset 0x024) stores bits 4..1 with the same positions as status. All other bits read zero.
- R5: The source register of environment e is at 0x800 + e*0x80. Bit n (n < NUM_PIPES) follows pipe_irq_i[n]. Bit 31 is set when any status bit and its enable bit are both set. All other bits read zero, and writes to the source register change nothing.
- R6: The unmask register of environment e is at 0x804 + e*0x80. It stores bit 31 and the bits of implemented pipes, and other bits read zero. Writing 0 to it masks every interrupt of that environment.
- R7: irq_o[e] is high exactly when the source word ANDed with the unmask register of environment e is nonzero. The output is combinational from the current pipe inputs and the registered state.
- R8: Read data appears on reg_rdata_o in the cycle after reg_rd_i is high and holds until the next read. A read of any unmapped offset, or of an environment index at or beyond NUM_ENV, returns zero.
- R9: A write to one environment's unmask register leaves the unmask register and line of every other environment unchanged.
- R10: A global cause drives an environment's line only while its enable bit and that environment's unmask bit 31 are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pipe_irq_i | input | NUM_PIPES | Level interrupt request of each pipe |
| gevt_i | input | 4 | Global cause pulses: bus response error, error, empty, timer |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | ADDR_W | Byte offset of the register |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, valid the cycle after a read |
| irq_o | output | NUM_ENV | Level-high interrupt line per environment |

## Verification
The bench builds the block with NUM_PIPES = 6 and NUM_ENV = 2. With these values, the unimplemented pipe bits 30..6 can be shown to read back as zero in both the source and unmask registers. A read of environment index 5 lands past the last environment and must return zero. Two environments are enough to show that unmask writes stay separate from each other. They also allow the controller-level bit to reach one line while the other line follows a single pipe.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;

    localparam int unsigned GC_W       = 4;       // number of global causes
    localparam int unsigned GC_LSB     = 1;       // status bit of cause 0
    localparam int unsigned WORD_W     = 32;
    localparam int unsigned GLB_BIT    = 31;      // controller-level bit in source word

    localparam int unsigned OFS_GSTAT  = 'h020;
    localparam int unsigned OFS_GEN    = 'h024;
    localparam int unsigned OFS_GCLR   = 'h028;
    localparam int unsigned ENV_BASE   = 'h800;
    localparam int unsigned ENV_STRIDE = 'h080;
    localparam int unsigned ENV_MSK    = 'h004;

    typedef struct packed {
        logic [GC_W-1:0] stat;
        logic [GC_W-1:0] en;
    } gc_state_t;

    function automatic int unsigned env_src_ofs(int unsigned e);
        return ENV_BASE + e * ENV_STRIDE;
    endfunction

    function automatic int unsigned env_msk_ofs(int unsigned e);
        return ENV_BASE + e * ENV_STRIDE + ENV_MSK;
    endfunction

    function automatic logic [WORD_W-1:0] gc_to_word(logic [GC_W-1:0] v);
        logic [WORD_W-1:0] w;
        w = '0;
        w[GC_LSB +: GC_W] = v;
        return w;
    endfunction

endpackage

// File: rtl/irqagg_gcause.sv
module irqagg_gcause
    import irqagg_pkg::*;
(
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic [GC_W-1:0] evt_i,
    input  logic            en_we_i,
    input  logic            clr_we_i,
    input  logic [GC_W-1:0] wdata_i,
    output logic [GC_W-1:0] stat_o,
    output logic [GC_W-1:0] en_o,
    output logic            cause_o
);

    gc_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (en_we_i) begin
            state_d.en = wdata_i;
        end
        if (clr_we_i) begin
            state_d.stat = state_q.stat & ~wdata_i;
        end
        // a new event always wins over a clear in the same cycle
        state_d.stat = state_d.stat | evt_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign stat_o  = state_q.stat;
    assign en_o    = state_q.en;
    assign cause_o = |(state_q.stat & state_q.en);

endmodule

// File: rtl/irqagg_envmask.sv
module irqagg_envmask #(
    parameter int unsigned NUM_PIPES = 31
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               we_i,
    input  logic [NUM_PIPES:0] wdata_i,
    input  logic [NUM_PIPES:0] src_i,
    output logic [NUM_PIPES:0] mask_o,
    output logic               irq_o
);

    typedef struct packed {
        logic [NUM_PIPES:0] mask;
    } env_state_t;

    env_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (we_i) begin
            state_d.mask = wdata_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign mask_o = state_q.mask;
    assign irq_o  = |(src_i & state_q.mask);

endmodule

// File: rtl/irqagg_regif.sv
module irqagg_regif
    import irqagg_pkg::*;
#(
    parameter int unsigned NUM_ENV = 4,
    parameter int unsigned ADDR_W  = 12
) (
    input  logic                        clk_i,
    input  logic                        rst_ni,
    input  logic                        wr_i,
    input  logic                        rd_i,
    input  logic [ADDR_W-1:0]           addr_i,
    input  logic [GC_W-1:0]             gstat_i,
    input  logic [GC_W-1:0]             gen_i,
    input  logic [WORD_W-1:0]           src_word_i,
    input  logic [NUM_ENV*WORD_W-1:0]   mask_words_i,
    output logic                        gen_we_o,
    output logic                        gclr_we_o,
    output logic [NUM_ENV-1:0]          mask_we_o,
    output logic [WORD_W-1:0]           rdata_o
);

    typedef struct packed {
        logic [WORD_W-1:0] rdata;
    } rd_state_t;

    rd_state_t         state_d, state_q;
    logic [WORD_W-1:0] rd_mux;

    always_comb begin
        gen_we_o  = wr_i && (addr_i == ADDR_W'(OFS_GEN));
        gclr_we_o = wr_i && (addr_i == ADDR_W'(OFS_GCLR));
        mask_we_o = '0;
        rd_mux    = '0;
        if (addr_i == ADDR_W'(OFS_GSTAT)) begin
            rd_mux = gc_to_word(gstat_i);
        end
        if (addr_i == ADDR_W'(OFS_GEN)) begin
            rd_mux = gc_to_word(gen_i);
        end
        for (int unsigned e = 0; e < NUM_ENV; e++) begin
            if (addr_i == ADDR_W'(env_src_ofs(e))) begin
                rd_mux = src_word_i;
            end
            if (addr_i == ADDR_W'(env_msk_ofs(e))) begin
                rd_mux       = mask_words_i[e*WORD_W +: WORD_W];
                mask_we_o[e] = wr_i;
            end
        end
    end

    always_comb begin
        state_d = state_q;
        if (rd_i) begin
            state_d.rdata = rd_mux;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign rdata_o = state_q.rdata;

endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
    import irqagg_pkg::*;
#(
    parameter int unsigned NUM_PIPES = 31,
    parameter int unsigned NUM_ENV   = 4,
    parameter int unsigned ADDR_W    = 12
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic [NUM_PIPES-1:0] pipe_irq_i,
    input  logic [GC_W-1:0]      gevt_i,
    input  logic                 reg_wr_i,
    input  logic                 reg_rd_i,
    input  logic [ADDR_W-1:0]    reg_addr_i,
    input  logic [WORD_W-1:0]    reg_wdata_i,
    output logic [WORD_W-1:0]    reg_rdata_o,
    output logic [NUM_ENV-1:0]   irq_o
);

    localparam int unsigned CSRC_W = NUM_PIPES + 1;   // compact source: pipes + global

    logic [GC_W-1:0]           gstat_w;
    logic [GC_W-1:0]           gen_w;
    logic                      gcause_w;
    logic                      gen_we_w;
    logic                      gclr_we_w;
    logic [NUM_ENV-1:0]        mask_we_w;
    logic [CSRC_W-1:0]         csrc_w;
    logic [CSRC_W-1:0]         cwdata_w;
    logic [WORD_W-1:0]         src_word_w;
    logic [NUM_ENV*WORD_W-1:0] mask_words_w;

    irqagg_gcause u_gcause (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .evt_i    (gevt_i),
        .en_we_i  (gen_we_w),
        .clr_we_i (gclr_we_w),
        .wdata_i  (reg_wdata_i[GC_LSB +: GC_W]),
        .stat_o   (gstat_w),
        .en_o     (gen_w),
        .cause_o  (gcause_w)
    );

    assign csrc_w   = {gcause_w, pipe_irq_i};
    assign cwdata_w = {reg_wdata_i[GLB_BIT], reg_wdata_i[NUM_PIPES-1:0]};

    always_comb begin
        src_word_w                  = '0;
        src_word_w[NUM_PIPES-1:0]   = pipe_irq_i;
        src_word_w[GLB_BIT]         = gcause_w;
    end

    for (genvar e = 0; e < NUM_ENV; e++) begin : g_env
        logic [CSRC_W-1:0] mask_w;

        irqagg_envmask #(
            .NUM_PIPES (NUM_PIPES)
        ) u_envmask (
            .clk_i   (clk_i),
            .rst_ni  (rst_ni),
            .we_i    (mask_we_w[e]),
            .wdata_i (cwdata_w),
            .src_i   (csrc_w),
            .mask_o  (mask_w),
            .irq_o   (irq_o[e])
        );

        always_comb begin
            mask_words_w[e*WORD_W +: WORD_W]                = '0;
            mask_words_w[e*WORD_W +: NUM_PIPES]             = mask_w[NUM_PIPES-1:0];
            mask_words_w[e*WORD_W + GLB_BIT]                = mask_w[NUM_PIPES];
        end
    end

    irqagg_regif #(
        .NUM_ENV (NUM_ENV),
        .ADDR_W  (ADDR_W)
    ) u_regif (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .wr_i         (reg_wr_i),
        .rd_i         (reg_rd_i),
        .addr_i       (reg_addr_i),
        .gstat_i      (gstat_w),
        .gen_i        (gen_w),
        .src_word_i   (src_word_w),
        .mask_words_i (mask_words_w),
        .gen_we_o     (gen_we_w),
        .gclr_we_o    (gclr_we_w),
        .mask_we_o    (mask_we_w),
        .rdata_o      (reg_rdata_o)
    );

endmodule

// File: rtl/irq_aggregator_chk.sv
module irq_aggregator_chk
    import irqagg_pkg::*;
#(
    parameter int unsigned NUM_PIPES = 31,
    parameter int unsigned NUM_ENV   = 4,
    parameter int unsigned ADDR_W    = 12
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [GC_W-1:0]      evt_i,
    input logic [GC_W-1:0]      gstat,
    input logic [GC_W-1:0]      gen,
    input logic [NUM_PIPES-1:0] pipe_irq_i,
    input logic [NUM_ENV-1:0]   irq_o,
    input logic                 reg_wr_i,
    input logic                 reg_rd_i,
    input logic [ADDR_W-1:0]    reg_addr_i,
    input logic [WORD_W-1:0]    reg_wdata_i,
    input logic [WORD_W-1:0]    reg_rdata_o
);

    assert_evt_latches_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i != '0) |=> ((gstat & $past(evt_i)) == $past(evt_i)));

    assert_no_spurious_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((gstat & ~$past(gstat) & ~$past(evt_i)) == '0));

    assert_clear_loses_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((evt_i != '0) && reg_wr_i && (reg_addr_i == ADDR_W'(OFS_GCLR)))
        |=> ((gstat & $past(evt_i)) == $past(evt_i)));

    assert_irq_has_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o != '0) |-> ((pipe_irq_i != '0) || ((gstat & gen) != '0)));

    assert_zero_mask_silences_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_i && (reg_addr_i == ADDR_W'(env_msk_ofs(0))) && (reg_wdata_i == '0))
        |=> !irq_o[0]);

    assert_rdata_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd_i |=> $stable(reg_rdata_o));

endmodule

bind irq_aggregator irq_aggregator_chk #(
    .NUM_PIPES (NUM_PIPES),
    .NUM_ENV   (NUM_ENV),
    .ADDR_W    (ADDR_W)
) u_chk (
    .clk         (clk_i),
    .rst_n       (rst_ni),
    .evt_i       (gevt_i),
    .gstat       (gstat_w),
    .gen         (gen_w),
    .pipe_irq_i  (pipe_irq_i),
    .irq_o       (irq_o),
    .reg_wr_i    (reg_wr_i),
    .reg_rd_i    (reg_rd_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wdata_i (reg_wdata_i),
    .reg_rdata_o (reg_rdata_o)
);

// File: tb/tb_irq_aggregator.sv
`timescale 1ns/1ps
module tb_irq_aggregator;

    localparam int NP = 6;
    localparam int NE = 2;
    localparam int AW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] pipe_irq_i = '0;
    logic [3:0]    gevt_i = '0;
    logic          reg_wr_i = 1'b0;
    logic          reg_rd_i = 1'b0;
    logic [AW-1:0] reg_addr_i = '0;
    logic [31:0]   reg_wdata_i = '0;
    logic [31:0]   reg_rdata_o;
    logic [NE-1:0] irq_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    // behavioural reference state
    logic [31:0] m_stat, m_en, m_pipes;
    logic [31:0] m_mask [NE];

    always #10 clk = ~clk;   // 50 MHz

    irq_aggregator #(.NUM_PIPES(NP), .NUM_ENV(NE), .ADDR_W(AW)) dut (
        .clk_i(clk), .rst_ni(rst_n), .pipe_irq_i(pipe_irq_i), .gevt_i(gevt_i),
        .reg_wr_i(reg_wr_i), .reg_rd_i(reg_rd_i), .reg_addr_i(reg_addr_i),
        .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o), .irq_o(irq_o)
    );

    function automatic logic [31:0] m_src();
        return m_pipes | (((m_stat & m_en) != 0) ? 32'h8000_0000 : 32'h0);
    endfunction

    function automatic logic [NE-1:0] m_irq();
        logic [NE-1:0] v;
        for (int e = 0; e < NE; e++) v[e] = ((m_src() & m_mask[e]) != 0);
        return v;
    endfunction

    function automatic logic [31:0] m_read(logic [AW-1:0] a);
        if (a == 12'h020) return m_stat;
        if (a == 12'h024) return m_en;
        for (int e = 0; e < NE; e++) begin
            if (a == 12'(32'h800 + e*32'h80)) return m_src();
            if (a == 12'(32'h804 + e*32'h80)) return m_mask[e];
        end
        return 32'h0;
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step(bit wr, bit rd, logic [AW-1:0] addr, logic [31:0] wd,
                        logic [NP-1:0] pipes, logic [3:0] evt, string tag);
        logic [31:0] exp_rd;
        reg_wr_i = wr; reg_rd_i = rd; reg_addr_i = addr; reg_wdata_i = wd;
        pipe_irq_i = pipes; gevt_i = evt;
        m_pipes = 32'(pipes);
        exp_rd = m_read(addr);
        @(posedge clk);
        if (wr) begin
            if (addr == 12'h024) m_en = wd & 32'h1E;
            if (addr == 12'h028) m_stat = m_stat & ~wd;
            for (int e = 0; e < NE; e++)
                if (addr == 12'(32'h804 + e*32'h80)) m_mask[e] = wd & 32'h8000_003F;
        end
        m_stat = m_stat | (32'(evt) << 1);
        @(negedge clk);
        reg_wr_i = 1'b0; reg_rd_i = 1'b0; gevt_i = '0;
        check({tag, " irq"}, 32'(irq_o), 32'(m_irq()));
        if (rd) check({tag, " rdata"}, reg_rdata_o, exp_rd);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        m_stat = 0; m_en = 0; m_pipes = 0;
        for (int e = 0; e < NE; e++) m_mask[e] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check("R1 irq", 32'(irq_o), 32'h0);
        check("R1 rdata", reg_rdata_o, 32'h0);
        step(0, 1, 12'h020, 0, 0, 0, "R1");
        step(0, 1, 12'h024, 0, 0, 0, "R1");
        step(0, 1, 12'h804, 0, 0, 0, "R1");
        step(0, 1, 12'h880, 0, 0, 0, "R1");
        // R4 enable register bits
        step(1, 0, 12'h024, 32'hFFFF_FFFF, 0, 0, "R4");
        step(0, 1, 12'h024, 0, 0, 0, "R4");
        // R2 sticky status, clear with zero, clear with one
        step(0, 0, 12'h000, 0, 0, 4'b0010, "R2");
        step(0, 1, 12'h020, 0, 0, 0, "R2");
        step(1, 0, 12'h028, 32'h0, 0, 0, "R2");
        step(0, 1, 12'h020, 0, 0, 0, "R2");
        step(0, 1, 12'h028, 0, 0, 0, "R2");
        step(1, 0, 12'h028, 32'h4, 0, 0, "R2");
        step(0, 1, 12'h020, 0, 0, 0, "R2");
        // R3 clear and event collide on timer
        step(1, 0, 12'h028, 32'h10, 0, 4'b1000, "R3");
        step(0, 1, 12'h020, 0, 0, 0, "R3");
        // R5 source word, writes ignored
        step(0, 1, 12'h800, 0, 6'b100101, 0, "R5");
        step(1, 0, 12'h800, 32'h0, 6'b100101, 0, "R5");
        step(0, 1, 12'h800, 0, 6'b100101, 0, "R5");
        step(0, 1, 12'h880, 0, 6'b010010, 0, "R5");
        // R6 mask stores implemented bits, R9 other env untouched
        step(1, 0, 12'h804, 32'hFFFF_FFFF, 6'b010010, 0, "R6");
        step(0, 1, 12'h804, 0, 6'b010010, 0, "R6");
        step(0, 1, 12'h884, 0, 6'b010010, 0, "R9");
        // R10 global cause reaches env1 only via bit 31 and enable
        step(1, 0, 12'h884, 32'h8000_0000, 6'b000000, 0, "R10");
        step(1, 0, 12'h024, 32'h0, 0, 0, "R10");
        step(1, 0, 12'h024, 32'h10, 0, 0, "R10");
        step(1, 0, 12'h028, 32'h1E, 0, 0, "R10");
        step(0, 0, 12'h000, 0, 0, 4'b0001, "R10");
        step(1, 0, 12'h024, 32'h02, 0, 0, "R10");
        // R7 single pipe through env1 mask
        step(1, 0, 12'h884, 32'h4, 6'b000000, 0, "R7");
        step(0, 0, 12'h000, 0, 6'b000100, 0, "R7");
        step(0, 0, 12'h000, 0, 6'b111011, 0, "R7");
        step(0, 0, 12'h000, 0, 6'b000100, 0, "R7");
        // R6 zero mask silences env0 with sources active, R9 env1 keeps its line
        step(1, 0, 12'h804, 32'h0, 6'b000100, 0, "R6");
        step(0, 1, 12'h884, 0, 6'b000100, 0, "R9");
        // R8 unmapped and out-of-range environment reads, hold without read
        step(0, 1, 12'h100, 0, 6'b000100, 0, "R8");
        step(0, 1, 12'h028, 0, 6'b000100, 0, "R8");
        step(0, 1, 12'hA84, 0, 6'b000100, 0, "R8");
        step(0, 1, 12'h884, 0, 6'b000100, 0, "R8");
        step(0, 0, 12'h100, 0, 6'b000100, 0, "R8");
        check("R8 hold", reg_rdata_o, 32'h4);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule